// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Override

The block turns bytes written by software into asynchronous serial frames on a single output line. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. A one-cycle baud pulse from outside sets the pace, and each bit lasts exactly one pulse period. A holding register takes writes at any time. At the start of each frame it hands its byte to a shift register. An empty flag shows when that handoff has happened, so the next byte can be written while the current frame is still on the line.

An end flag reports that the line has gone quiet: the last stop bit has finished and no byte is waiting. A software-controlled line override can force the output to a fixed level whatever the transmitter is doing. Driving the override low and then clearing the enable holds the line at zero for as long as required, which is how a break condition is sent.

Top module: `sertx_core`

## Requirements
- R1: During and after reset `txd` is 1, `tx_empty` is 1 and `tx_end` is 1. Whenever `pin_force` is 0 and no frame is in progress, `txd` is 1.
- R2: A write (`wr_stb`=1 at a rising edge) is accepted whatever the value of `tx_empty`. It stores `wr_byte`, and from the next cycle `tx_empty` and `tx_end` read 0.
- R3: A frame starts on a clock edge where `baud_tick`=1, `tx_en`=1 and `tx_empty`=0. `txd` then shows 0 (start bit) from the following cycle, followed by the 8 data bits least significant first, then the parity bit when enabled, then a stop bit of 1. Each bit changes in the cycle after a `baud_tick` edge and lasts one tick period.
- R4: `tx_empty` rises at the edge that moves the byte into the shift register, which is the first edge of the start bit, and not at the end of the frame.
- R5: The value of `par_en` when a frame is loaded decides whether that frame carries a parity bit after the most significant data bit. With `par_odd`=0 the bit is the XOR of the 8 data bits (even parity). With `par_odd`=1 it is the inverse of that XOR (odd parity).
- R6: A second write made before the stored byte is loaded replaces it. Only the later byte is transmitted, and the earlier byte is lost.
- R7: A byte written while a frame is in progress (`tx_empty`=1) is loaded at the tick that ends the stop bit. Its start bit follows the stop bit with no idle period between them.
- R8: `tx_end` rises at the tick that ends a stop bit when no byte is waiting. It stays 0 across back-to-back frames.
- R9: While `tx_en`=0 no frame starts and a stored byte stays pending. Clearing `tx_en` during a frame returns the line to idle (1) in the next cycle, discards that frame, and leaves `tx_empty` at 1.
- R10: While `pin_force`=1, `txd` equals `pin_level` regardless of the transmitter. Setting `pin_level`=0 and `pin_force`=1 and then clearing `tx_en` holds `txd` at 0 (break) until the override is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; 0 resets the frame logic at once |
| par_en | input | 1 | Append a parity bit to frames loaded while 1 |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_byte | input | 8 | Byte to store |
| pin_force | input | 1 | Line override: 1 drives `txd` from `pin_level` |
| pin_level | input | 1 | Level driven while the override is active |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register has been handed to the shifter |
| tx_end | output | 1 | Last stop bit finished and nothing is pending |

## Verification
The bench goes after the moment of the handoff. A design that raised the empty flag only at the end of the frame would fail the check made in the first cycle of the start bit. A design that ignored a write made during a frame would leave the scoreboard waiting for a byte that never arrives. Two writes squeezed between ticks test that the newer byte wins: a design that loaded on the first write would send a stale byte. Two further tests clear the enable in the middle of a frame and then force the line low. They catch a transmitter that finishes the frame anyway, that restarts after being re-enabled, or whose override yields to the idle level. A design with the parity sense inverted, or with the data bits in reverse order, fails the byte-for-byte comparison of every frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;

  // Parity over a zero-extended word: even parity gives the XOR, odd parity its inverse.
  function automatic logic frame_parity(input logic [31:0] word, input logic odd);
    return (^word) ^ odd;
  endfunction

  // Level the frame logic puts on the line in each state.
  function automatic logic state_level(input tx_state_e st, input logic data_bit,
                                       input logic par_bit);
    logic lvl;
    case (st)
      TX_START: lvl = 1'b0;
      TX_DATA:  lvl = data_bit;
      TX_PAR:   lvl = par_bit;
      default:  lvl = 1'b1;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              load_go,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q
);

  // A write always lands; it wins over a load in the same cycle for the flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (wr_stb) begin
        hold_q  <= wr_byte;
        empty_q <= 1'b0;
      end else if (load_go) begin
        empty_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              baud_tick,
  input  logic              hold_empty,
  input  logic [DATA_W-1:0] hold_q,
  output logic              load_go,
  output logic              stop_done,
  output logic              busy,
  output logic              line_bit
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  idx_q;
  logic              par_q;
  logic              with_par_q;

  logic can_load;
  assign can_load  = (state_q == TX_IDLE) || (state_q == TX_STOP);
  assign load_go   = baud_tick && tx_en && !hold_empty && can_load;
  assign stop_done = baud_tick && tx_en && (state_q == TX_STOP);
  assign busy      = (state_q != TX_IDLE);
  assign line_bit  = state_level(state_q, shreg_q[0], par_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state_q    <= TX_IDLE;
      shreg_q    <= '0;
      idx_q      <= '0;
      par_q      <= 1'b0;
      with_par_q <= 1'b0;
    end else if (load_go) begin
      state_q    <= TX_START;
      shreg_q    <= hold_q;
      idx_q      <= '0;
      par_q      <= frame_parity(32'(hold_q), par_odd);
      with_par_q <= par_en;
    end else if (baud_tick) begin
      case (state_q)
        TX_START: state_q <= TX_DATA;
        TX_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= with_par_q ? TX_PAR : TX_STOP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        TX_PAR:  state_q <= TX_STOP;
        TX_STOP: state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sertx_linemux.sv
module sertx_linemux (
  input  logic pin_force,
  input  logic pin_level,
  input  logic line_bit,
  output logic txd
);

  assign txd = pin_force ? pin_level : line_bit;

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              pin_force,
  input  logic              pin_level,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_end
);

  logic [DATA_W-1:0] hold_q;
  logic              hold_empty;
  logic              load_go;
  logic              stop_done;
  logic              busy;
  logic              line_bit;
  logic              end_q;

  sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .load_go (load_go),
    .hold_q  (hold_q),
    .empty_q (hold_empty)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .baud_tick  (baud_tick),
    .hold_empty (hold_empty),
    .hold_q     (hold_q),
    .load_go    (load_go),
    .stop_done  (stop_done),
    .busy       (busy),
    .line_bit   (line_bit)
  );

  sertx_linemux u_mux (
    .pin_force (pin_force),
    .pin_level (pin_level),
    .line_bit  (line_bit),
    .txd       (txd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       end_q <= 1'b1;
    else if (wr_stb)                  end_q <= 1'b0;
    else if (stop_done && hold_empty) end_q <= 1'b1;
  end

  assign tx_empty = hold_empty;
  assign tx_end   = end_q;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic tx_empty,
  input logic tx_end,
  input logic load_go,
  input logic stop_done,
  input logic busy,
  input logic line_bit
);

  // R2: an accepted write clears both flags
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!tx_empty && !tx_end));

  // R4: the handoff itself marks the register empty
  a_r4_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && !wr_stb) |=> tx_empty);

  // R3: a load is followed by the start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (busy && !line_bit));

  // R8: end of stop bit with nothing pending raises the end flag
  a_r8_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && tx_empty && !wr_stb) |=> tx_end);

  // R9: clearing the enable idles the frame logic in the next cycle
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && line_bit));

  // R1: with no frame in progress the line level is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_bit);

endmodule

bind sertx_core sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .wr_stb    (wr_stb),
  .tx_empty  (tx_empty),
  .tx_end    (tx_end),
  .load_go   (load_go),
  .stop_done (stop_done),
  .busy      (busy),
  .line_bit  (line_bit)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       pin_force = 1'b0;
  logic       pin_level = 1'b1;
  logic       txd;
  logic       tx_empty;
  logic       tx_end;

  sertx_core i_sertx_core (
    .clk (clk), .rst_n (rst_n), .tx_en (tx_en), .par_en (par_en),
    .par_odd (par_odd), .baud_tick (baud_tick), .wr_stb (wr_stb),
    .wr_byte (wr_byte), .pin_force (pin_force), .pin_level (pin_level),
    .txd (txd), .tx_empty (tx_empty), .tx_end (tx_end)
  );

  always #4 clk = ~clk;  // 8 ns period

  typedef struct {
    logic [7:0] data;
    logic       has_par;
    logic       par;
  } frame_t;

  frame_t exp_q[$];
  int     n_run = 0;
  int     n_fail = 0;
  bit     finished = 0;
  bit     mon_on = 0;
  int     frames_seen = 0;
  int     last_gap = 0;

  function automatic logic ref_par(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    return odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // baud pulse generator
  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // driver: writes a byte and optionally queues the frame it should produce
  task automatic put_byte(input logic [7:0] b, input bit push);
    frame_t f;
    @(negedge clk);
    wr_byte = b;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
    if (push) begin
      f.data = b; f.has_par = par_en; f.par = ref_par(b, par_odd);
      exp_q.push_back(f);
    end
  endtask

  task automatic next_tick();
    @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic wait_end();
    int n = 0;
    @(negedge clk);
    while (!tx_end && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor: samples the line once per bit and compares frames with the queue
  initial begin
    int         st;
    int         idx;
    int         gap;
    logic [7:0] got;
    logic       pbit;
    frame_t     e;
    st = 0; idx = 0; gap = 0; got = '0; pbit = 1'b0;
    forever begin
      @(posedge clk iff baud_tick);
      @(negedge clk);
      if (!mon_on) begin
        st = 0; gap = 0;
      end else begin
        case (st)
          0: if (txd == 1'b0) begin st = 1; idx = 0; last_gap = gap; end
             else gap++;
          1: begin
               got[idx] = txd;
               idx++;
               if (idx == 8) st = par_en ? 2 : 3;
             end
          2: begin pbit = txd; st = 3; end
          default: begin
            check("R3", "stop bit", 32'(txd), 32'd1);
            if (exp_q.size() == 0) begin
              n_run++; n_fail++;
              $display("FAIL R3 unexpected frame: got %0h expected none", got);
            end else begin
              e = exp_q.pop_front();
              check("R3", "frame data LSB first", 32'(got), 32'(e.data));
              if (e.has_par) check("R5", "parity bit", 32'(pbit), 32'(e.par));
            end
            frames_seen++;
            gap = 0;
            st = 0;
          end
        endcase
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1", "txd in reset", 32'(txd), 32'd1);
    check("R1", "tx_empty in reset", 32'(tx_empty), 32'd1);
    check("R1", "tx_end in reset", 32'(tx_end), 32'd1);
    rst_n = 1'b1;
    tx_en = 1'b1;
    mon_on = 1;
    repeat (3) next_tick();
    check("R1", "idle line", 32'(txd), 32'd1);

    // single frame, no parity
    base = frames_seen;
    put_byte(8'hA5, 1);
    check("R2", "tx_empty after write", 32'(tx_empty), 32'd0);
    check("R2", "tx_end after write", 32'(tx_end), 32'd0);
    next_tick();
    check("R4", "tx_empty at handoff", 32'(tx_empty), 32'd1);
    check("R3", "start bit", 32'(txd), 32'd0);
    wait_end();
    check("R8", "tx_end after frame", 32'(tx_end), 32'd1);
    check("R3", "frames after single", 32'(frames_seen), 32'(base + 1));

    // even parity, back to back
    par_en = 1'b1; par_odd = 1'b0;
    base = frames_seen;
    put_byte(8'h3C, 1);
    next_tick();
    put_byte(8'h07, 1);
    repeat (12) next_tick();
    check("R8", "tx_end during second frame", 32'(tx_end), 32'd0);
    wait_end();
    check("R7", "no idle gap", 32'(last_gap), 32'd0);
    check("R5", "frames even parity", 32'(frames_seen), 32'(base + 2));

    // odd parity, back to back
    par_odd = 1'b1;
    base = frames_seen;
    put_byte(8'hFF, 1);
    next_tick();
    put_byte(8'h00, 1);
    wait_end();
    check("R7", "no idle gap odd", 32'(last_gap), 32'd0);
    check("R5", "frames odd parity", 32'(frames_seen), 32'(base + 2));

    // overwrite before load
    par_en = 1'b0; par_odd = 1'b0;
    base = frames_seen;
    @(posedge clk iff baud_tick);
    @(negedge clk);
    wr_byte = 8'h11; wr_stb = 1'b1;
    @(negedge clk);
    wr_byte = 8'hE2;
    @(negedge clk);
    wr_stb = 1'b0;
    begin
      frame_t f;
      f.data = 8'hE2; f.has_par = 1'b0; f.par = 1'b0;
      exp_q.push_back(f);
    end
    wait_end();
    check("R6", "only newer byte sent", 32'(frames_seen), 32'(base + 1));

    // disabled: byte stays pending
    tx_en = 1'b0;
    base = frames_seen;
    put_byte(8'h5A, 1);
    repeat (3) next_tick();
    check("R9", "line idle while disabled", 32'(txd), 32'd1);
    check("R9", "byte pending while disabled", 32'(tx_empty), 32'd0);
    tx_en = 1'b1;
    wait_end();
    check("R9", "pending byte sent on enable", 32'(frames_seen), 32'(base + 1));

    // abort in mid frame
    mon_on = 0;
    put_byte(8'h81, 0);
    next_tick();
    repeat (3) next_tick();
    tx_en = 1'b0;
    @(negedge clk);
    check("R9", "line idle after abort", 32'(txd), 32'd1);
    check("R9", "tx_empty after abort", 32'(tx_empty), 32'd1);
    tx_en = 1'b1;
    repeat (3) next_tick();
    check("R9", "aborted frame not resumed", 32'(txd), 32'd1);

    // break through the override
    put_byte(8'hC3, 0);
    next_tick();
    repeat (2) next_tick();
    pin_level = 1'b0;
    pin_force = 1'b1;
    @(negedge clk);
    check("R10", "override low", 32'(txd), 32'd0);
    tx_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      next_tick();
      check("R10", "break held low", 32'(txd), 32'd0);
    end
    pin_level = 1'b1;
    @(negedge clk);
    check("R10", "override high", 32'(txd), 32'd1);
    pin_force = 1'b0;
    tx_en = 1'b1;
    next_tick();
    check("R1", "idle after break", 32'(txd), 32'd1);
    mon_on = 1;
    repeat (2) next_tick();

    // recovery frame
    base = frames_seen;
    put_byte(8'h96, 1);
    wait_end();
    check("R3", "frame after break", 32'(frames_seen), 32'(base + 1));
    check("R3", "scoreboard drained", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule